// File: doc/BRIEF.md
# Serial bus frame receiver

This block listens on a shared single-wire serial bus and rebuilds each frame from one sample per bit slot. A timing front end does the analog bit-cell recovery. It hands the block a start-detect pulse and a strobe for every slot that follows, together with the sampled bus level. The receiver then works through the frame field by field. First it reads the frame type bit, which separates broadcast frames from normal frames. It then reads the sender address, the destination address, a control nibble, a byte count and that many data bytes. It checks even parity on every field and decides whether the frame is meant for this unit.

For normal frames that are meant for this unit, the receiver pulls the bus low in each acknowledge slot when the field arrived clean. When a field fails parity it leaves that slot high. In broadcast frames it stays passive at all times. Accepted header values and each data byte leave the block through one-cycle valid pulses. A final pulse at the end of the frame reports the frame type, the sender address and whether any parity error was seen. Frames that are not meant for this unit are followed silently until they end and produce no output.

Top module: `sbus_frame_rx`

## Requirements
- R1: While rst_ni is low, and after it is released, every output is 0 until a frame is received.
- R2: A start_i pulse moves the receiver out of idle. The next accepted slot is the frame type bit: 0 means broadcast and 1 means normal. Slot strobes that arrive while idle are ignored.
- R3: The fields arrive in this fixed order, each sent MSB first and each followed by one parity slot: sender address (12 bits), destination address (12 bits), control (4 bits), length (8 bits), then the data bytes (8 bits each). Every field except the sender address is followed by one acknowledge slot after its parity slot.
- R4: In a broadcast frame ack_pull_o is never asserted.
- R5: A normal frame is addressed to this unit when the destination address equals unit_addr_i. A broadcast frame is addressed to this unit when its destination address is all ones (general broadcast) or when its upper 4 bits equal group_i (group broadcast). A parity error on the destination address makes the frame unaddressed.
- R6: A field's parity is good when the XOR of its data bits and its parity bit is 0. In a normal frame addressed to this unit, ack_pull_o (1 = drive the bus low = ACK) rises in the cycle after a good parity slot is accepted and falls in the cycle after the acknowledge slot is accepted. After a bad parity slot it stays 0, which is a NAK.
- R7: The length field gives the number N of data fields that follow. When N = 0 the frame ends at the acknowledge slot of the length field.
- R8: In an addressed frame, hdr_valid_o pulses for one cycle after the length parity slot and carries ctrl_o and len_o. byte_valid_o pulses for one cycle after each data parity slot and carries byte_o and byte_perr_o (1 = that byte failed parity). Unaddressed frames produce neither pulse.
- R9: In an addressed frame, done_o pulses for one cycle after the last acknowledge slot. With it come done_bcast_o (1 = broadcast), done_master_o (the sender address) and done_err_o (1 = at least one field of the frame failed parity). An unaddressed frame raises no done_o and still returns the receiver to idle.
- R10: A start_i pulse during a frame drops ack_pull_o in the next cycle and restarts reception at the frame type bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start bit detected by the front end |
| slot_valid_i | input | 1 | One bit slot sampled this cycle |
| slot_bit_i | input | 1 | Sampled bus level for the slot |
| unit_addr_i | input | 12 | This unit's address |
| group_i | input | 4 | This unit's broadcast group |
| ack_pull_o | output | 1 | Drive the bus low during the acknowledge slot |
| hdr_valid_o | output | 1 | Control and length valid pulse |
| ctrl_o | output | 4 | Received control value |
| len_o | output | 8 | Received byte count |
| byte_valid_o | output | 1 | Data byte valid pulse |
| byte_o | output | 8 | Received data byte |
| byte_perr_o | output | 1 | Data byte parity error |
| done_o | output | 1 | End of an addressed frame |
| done_bcast_o | output | 1 | Frame was broadcast |
| done_master_o | output | 12 | Sender address of the frame |
| done_err_o | output | 1 | Frame had a parity error |

## Verification
The hardest state to reach from the ports is a restart that arrives while the receiver is actively pulling an acknowledge slot low. The bench builds a partial normal frame aimed at this unit and stops right after the destination parity slot, where ack_pull_o is high. It then pulses start_i and checks that the pull is released, and that the complete frame sent next is still received correctly. Parity faults are placed in turn on each field, including the destination address. This shows that a corrupted address silences the unit, while a corrupted later field gives a NAK on that field only and sets the error flag.

// File: rtl/sbus_rx_pkg.sv
package sbus_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_BITS,
    ST_PAR,
    ST_ACK
  } st_e;

  typedef enum logic [2:0] {
    FD_MADDR,
    FD_SADDR,
    FD_CTRL,
    FD_LEN,
    FD_DATA
  } fd_e;
endpackage

// File: rtl/sbus_rx_shreg.sv
module sbus_rx_shreg #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      par_o  <= 1'b0;
    end else if (clr_i) begin
      data_o <= '0;
      par_o  <= 1'b0;
    end else if (en_i) begin
      data_o <= {data_o[W-2:0], bit_i};
      par_o  <= par_o ^ bit_i;
    end
  end
endmodule

// File: rtl/sbus_rx_match.sv
module sbus_rx_match #(
  parameter int ADDR_W = 12,
  parameter int GRP_W  = 4
) (
  input  logic [ADDR_W-1:0] sa_i,
  input  logic [ADDR_W-1:0] unit_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              bcast_i,
  output logic              hit_o
);
  logic general, group, exact;

  assign general = &sa_i;
  assign group   = sa_i[ADDR_W-1 -: GRP_W] == grp_i;
  assign exact   = sa_i == unit_i;
  assign hit_o   = bcast_i ? (general | group) : exact;
endmodule

// File: rtl/sbus_frame_rx.sv
module sbus_frame_rx
  import sbus_rx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int GRP_W  = 4,
  parameter int CTRL_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              slot_valid_i,
  input  logic              slot_bit_i,
  input  logic [ADDR_W-1:0] unit_addr_i,
  input  logic [GRP_W-1:0]  group_i,
  output logic              ack_pull_o,
  output logic              hdr_valid_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] len_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_perr_o,
  output logic              done_o,
  output logic              done_bcast_o,
  output logic [ADDR_W-1:0] done_master_o,
  output logic              done_err_o
);
  localparam int SR_W  = ADDR_W;
  localparam int CNT_W = $clog2(SR_W + 1);

  st_e               st_q;
  fd_e               fd_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, fw;
  logic              bcast_q, hit_q, err_q;
  logic [BYTE_W-1:0] rem_q;
  logic [ADDR_W-1:0] master_q;
  logic [SR_W-1:0]   sr_data;
  logic              sr_par, sr_clr, sr_en, perr_now, hit_now, ack_ok;

  always_comb begin
    unique case (fd_q)
      FD_MADDR, FD_SADDR: fw = CNT_W'(ADDR_W);
      FD_CTRL:            fw = CNT_W'(CTRL_W);
      default:            fw = CNT_W'(BYTE_W);
    endcase
  end

  assign cnt_nxt  = cnt_q + CNT_W'(1);
  assign sr_clr   = start_i | (slot_valid_i & (st_q != ST_BITS));
  assign sr_en    = slot_valid_i & (st_q == ST_BITS);
  assign perr_now = sr_par ^ slot_bit_i;
  assign ack_ok   = hit_q & ~bcast_q & ~perr_now;

  sbus_rx_shreg #(.W(SR_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sr_clr),
    .en_i   (sr_en),
    .bit_i  (slot_bit_i),
    .data_o (sr_data),
    .par_o  (sr_par)
  );

  sbus_rx_match #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_match (
    .sa_i    (sr_data[ADDR_W-1:0]),
    .unit_i  (unit_addr_i),
    .grp_i   (group_i),
    .bcast_i (bcast_q),
    .hit_o   (hit_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      fd_q          <= FD_MADDR;
      cnt_q         <= '0;
      bcast_q       <= 1'b0;
      hit_q         <= 1'b0;
      err_q         <= 1'b0;
      rem_q         <= '0;
      master_q      <= '0;
      ack_pull_o    <= 1'b0;
      hdr_valid_o   <= 1'b0;
      ctrl_o        <= '0;
      len_o         <= '0;
      byte_valid_o  <= 1'b0;
      byte_o        <= '0;
      byte_perr_o   <= 1'b0;
      done_o        <= 1'b0;
      done_bcast_o  <= 1'b0;
      done_master_o <= '0;
      done_err_o    <= 1'b0;
    end else begin
      hdr_valid_o  <= 1'b0;
      byte_valid_o <= 1'b0;
      done_o       <= 1'b0;
      if (start_i) begin
        st_q       <= ST_HDR;
        ack_pull_o <= 1'b0;
        hit_q      <= 1'b0;
        err_q      <= 1'b0;
      end else if (slot_valid_i) begin
        unique case (st_q)
          ST_HDR: begin
            bcast_q <= ~slot_bit_i;  // bus 0 = broadcast
            fd_q    <= FD_MADDR;
            cnt_q   <= '0;
            st_q    <= ST_BITS;
          end
          ST_BITS: begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt == fw) st_q <= ST_PAR;
          end
          ST_PAR: begin
            err_q <= err_q | perr_now;
            st_q  <= ST_ACK;
            unique case (fd_q)
              FD_MADDR: begin
                master_q <= sr_data[ADDR_W-1:0];
                fd_q     <= FD_SADDR;
                cnt_q    <= '0;
                st_q     <= ST_BITS;
              end
              FD_SADDR: begin
                hit_q      <= hit_now & ~perr_now;
                ack_pull_o <= hit_now & ~perr_now & ~bcast_q;
              end
              FD_CTRL: begin
                ctrl_o     <= sr_data[CTRL_W-1:0];
                ack_pull_o <= ack_ok;
              end
              FD_LEN: begin
                len_o       <= sr_data[BYTE_W-1:0];
                rem_q       <= sr_data[BYTE_W-1:0];
                hdr_valid_o <= hit_q;
                ack_pull_o  <= ack_ok;
              end
              default: begin
                byte_o       <= sr_data[BYTE_W-1:0];
                byte_perr_o  <= perr_now;
                byte_valid_o <= hit_q;
                rem_q        <= rem_q - BYTE_W'(1);
                ack_pull_o   <= ack_ok;
              end
            endcase
          end
          ST_ACK: begin
            ack_pull_o <= 1'b0;
            cnt_q      <= '0;
            st_q       <= ST_BITS;
            unique case (fd_q)
              FD_SADDR: fd_q <= FD_CTRL;
              FD_CTRL:  fd_q <= FD_LEN;
              default: begin
                fd_q <= FD_DATA;
                if (rem_q == '0) begin
                  st_q          <= ST_IDLE;
                  done_o        <= hit_q;
                  done_bcast_o  <= bcast_q;
                  done_master_o <= master_q;
                  done_err_o    <= err_q;
                end
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sbus_frame_rx_chk.sv
module sbus_frame_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic slot_valid_i,
  input logic ack_pull_o,
  input logic hdr_valid_o,
  input logic byte_valid_o,
  input logic done_o,
  input logic bcast_q,
  input logic hit_q
);
  AST_NO_ACK_IN_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pull_o |-> !bcast_q); // R4
  AST_ACK_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pull_o |-> hit_q); // R5
  AST_ACK_RISE_ON_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_pull_o) |-> $past(slot_valid_i)); // R6
  AST_BYTE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o); // R8
  AST_DONE_AFTER_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(slot_valid_i)); // R9
  AST_PULSES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hdr_valid_o, byte_valid_o, done_o})); // R8
  AST_START_DROPS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ack_pull_o); // R10
endmodule

bind sbus_frame_rx sbus_frame_rx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .slot_valid_i (slot_valid_i),
  .ack_pull_o   (ack_pull_o),
  .hdr_valid_o  (hdr_valid_o),
  .byte_valid_o (byte_valid_o),
  .done_o       (done_o),
  .bcast_q      (bcast_q),
  .hit_q        (hit_q)
);

// File: tb/sbus_frame_rx_test.sv
module sbus_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] UNIT = 12'h3A5;
  localparam logic [3:0]  GRP  = 4'hC;

  // bc: 1 = broadcast; bad: 0 none, 1 sender, 2 dest, 3 ctrl, 4 len, 5 first data
  typedef struct packed {
    logic        bc;
    logic [11:0] ma;
    logic [11:0] sa;
    logic [3:0]  ctl;
    logic [7:0]  len;
    logic [7:0]  seed;
    logic [2:0]  bad;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h101, 12'h3A5, 4'hA, 8'd2, 8'h11, 3'd0},
    '{1'b0, 12'h102, 12'h3A4, 4'h3, 8'd1, 8'h22, 3'd0},
    '{1'b1, 12'h103, 12'hFFF, 4'h5, 8'd2, 8'h33, 3'd0},
    '{1'b1, 12'h104, 12'hC12, 4'h6, 8'd1, 8'h44, 3'd0},
    '{1'b1, 12'h105, 12'h512, 4'h7, 8'd1, 8'h55, 3'd0},
    '{1'b0, 12'h106, 12'h3A5, 4'h8, 8'd0, 8'h66, 3'd0},
    '{1'b0, 12'h107, 12'h3A5, 4'h9, 8'd1, 8'h77, 3'd3},
    '{1'b0, 12'h108, 12'h3A5, 4'hB, 8'd1, 8'h88, 3'd2},
    '{1'b0, 12'h109, 12'h3A5, 4'hC, 8'd3, 8'h99, 3'd5},
    '{1'b0, 12'h10A, 12'h3A5, 4'hD, 8'd1, 8'hAA, 3'd4},
    '{1'b1, 12'hFFE, 12'hFFF, 4'hE, 8'd2, 8'hBB, 3'd5},
    '{1'b0, 12'h10B, 12'h3A5, 4'h1, 8'd1, 8'hCC, 3'd1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        slot_valid_i = 1'b0;
  logic        slot_bit_i = 1'b0;
  logic [11:0] unit_addr_i = UNIT;
  logic [3:0]  group_i = GRP;
  logic        ack_pull_o, hdr_valid_o, byte_valid_o, byte_perr_o;
  logic        done_o, done_bcast_o, done_err_o;
  logic [3:0]  ctrl_o;
  logic [7:0]  len_o, byte_o;
  logic [11:0] done_master_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sbus_frame_rx uut (
    .clk_i, .rst_ni, .start_i, .slot_valid_i, .slot_bit_i, .unit_addr_i, .group_i,
    .ack_pull_o, .hdr_valid_o, .ctrl_o, .len_o, .byte_valid_o, .byte_o, .byte_perr_o,
    .done_o, .done_bcast_o, .done_master_o, .done_err_o
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    slot_bit_i   = b;
    slot_valid_i = 1'b1;
    @(negedge clk_i);
    slot_valid_i = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic send_field(input logic [11:0] v, input int w, input bit bad);
    logic p;
    p = bad;
    for (int i = w - 1; i >= 0; i--) begin
      slot(v[i]);
      p = p ^ v[i];
    end
    slot(p);
  endtask

  task automatic quiet(input string tag);
    check(32'({ack_pull_o, hdr_valid_o, byte_valid_o, done_o}), 0, tag);
  endtask

  task automatic run_frame(input vec_t v);
    bit hit;
    logic [7:0] d;
    hit = (v.bad != 3'd2) &&
          (v.bc ? ((v.sa == 12'hFFF) || (v.sa[11:8] == GRP)) : (v.sa == UNIT));
    pulse_start();
    slot(~v.bc);
    send_field(v.ma, 12, v.bad == 3'd1);
    send_field(v.sa, 12, v.bad == 3'd2);
    check(32'(ack_pull_o), 32'(!v.bc && hit), "R5 dest ack");
    slot(1'b1);
    check(32'(ack_pull_o), 0, "R6 ack release");
    send_field({8'h0, v.ctl}, 4, v.bad == 3'd3);
    check(32'(ack_pull_o), 32'(!v.bc && hit && v.bad != 3'd3), "R6 ctrl ack");
    slot(1'b1);
    send_field({4'h0, v.len}, 8, v.bad == 3'd4);
    check(32'(hdr_valid_o), 32'(hit), "R8 hdr valid");
    if (hit) begin
      check(32'(ctrl_o), 32'(v.ctl), "R8 ctrl");
      check(32'(len_o), 32'(v.len), "R8 len");
    end
    check(32'(ack_pull_o), 32'(!v.bc && hit && v.bad != 3'd4), "R4 R6 len ack");
    slot(1'b1);
    for (int i = 0; i < int'(v.len); i++) begin
      d = v.seed + 8'(i * 37);
      send_field({4'h0, d}, 8, v.bad == 3'd5 && i == 0);
      check(32'(byte_valid_o), 32'(hit), "R8 byte valid");
      if (hit) begin
        check(32'(byte_o), 32'(d), "R8 byte");
        check(32'(byte_perr_o), 32'(v.bad == 3'd5 && i == 0), "R8 byte perr");
      end
      check(32'(ack_pull_o), 32'(!v.bc && hit && !(v.bad == 3'd5 && i == 0)), "R7 data ack");
      slot(1'b1);
    end
    check(32'(done_o), 32'(hit), "R9 done");
    if (hit) begin
      check(32'(done_bcast_o), 32'(v.bc), "R9 bcast flag");
      check(32'(done_master_o), 32'(v.ma), "R3 master");
      check(32'(done_err_o), 32'(v.bad != 3'd0), "R9 err");
    end
    @(negedge clk_i);
    quiet("R9 idle after frame");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    quiet("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    quiet("R1 after reset");
    check(32'({done_master_o, byte_o, len_o}), 0, "R1 data zero");

    for (int k = 0; k < NV; k++) run_frame(VECS[k]);

    // R2: strobes while idle are ignored
    slot(1'b0); slot(1'b1); slot(1'b0);
    quiet("R2 idle slots");
    run_frame(VECS[0]);

    // R10: restart while ack is being driven
    pulse_start();
    slot(1'b1);
    send_field(12'h0F0, 12, 1'b0);
    send_field(UNIT, 12, 1'b0);
    check(32'(ack_pull_o), 1, "R10 ack before restart");
    pulse_start();
    check(32'(ack_pull_o), 0, "R10 ack dropped");
    run_frame(VECS[8]);

    // R1: reset in mid frame
    pulse_start();
    slot(1'b1);
    send_field(12'h0F0, 12, 1'b0);
    send_field(UNIT, 12, 1'b0);
    rst_ni = 1'b0;
    #1;
    quiet("R1 reset mid frame");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_frame(VECS[2]);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule